// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This block works out where an instruction operand lives for a 16-bit processor with sixteen 16-bit registers. Register 0 holds the program counter, register 1 the stack pointer, register 2 the status word and register 3 the constant source; registers 4 to 15 are general purpose. From a mode code, a register index, a byte/word flag, an optional extension word, the program counter and the register's read data, the unit reports one of four outcomes. The operand is a register, a memory effective address, an immediate value, or an illegal request.

Source operands may use any of seven modes. Destination operands are limited to four modes. For indirect-with-post-increment the unit also asks the register file to write back the advanced pointer. The step is one for bytes and two for words. All results are registered and appear one clock after the request, with a valid strobe. The write-back request appears in the same cycle as the address it belongs to. All address sums wrap modulo 2^16.

Top module: `opaddr_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, and on the edge after it, `out_valid` and `wb_en` are 0.
- R2: Mode code 0 (register) gives `out_is_reg`=1 and `out_reg_idx` equal to the requested index, for both source and destination.
- R3: With `is_dst`=1, mode codes 4 to 7 give `out_illegal`=1. With `is_dst`=0, code 7 gives `out_illegal`=1. An illegal result carries no register, memory, immediate or write-back flag.
- R4: Mode code 1 (indexed) gives `out_is_mem`=1 with `out_addr` = `ext_word` + `reg_rdata`, modulo 2^16.
- R5: Mode code 2 (symbolic) gives `out_addr` = `ext_word` + `pc_in`, modulo 2^16, where `pc_in` is the address of the extension word.
- R6: Mode code 3 (absolute) gives `out_addr` = `ext_word`.
- R7: Mode code 4 (indirect, source only) gives `out_addr` = `reg_rdata` and `wb_en`=0.
- R8: Mode code 5 (post-increment, source only) gives `out_addr` = `reg_rdata`. In the same cycle it gives `wb_en`=1, `wb_idx` = the index, and `wb_data` = `reg_rdata` + 2 for words or + 1 for bytes, modulo 2^16.
- R9: Mode code 6 (immediate, source only) gives `out_is_imm`=1, `out_imm` = `ext_word`, `out_is_mem`=0 and `wb_en`=0.
- R10: Each request accepted with `req_valid`=1 gives exactly one result, with `out_valid`=1 on the next clock edge. Without a request, `out_valid` is 0 on the next edge.
- R11: `byte_op` changes only the post-increment step. Every other mode gives the same outcome and address for bytes and for words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| is_dst | input | 1 | 1 = destination operand, 0 = source |
| mode | input | 3 | Addressing mode code (0..7) |
| reg_idx | input | 4 | Register index named by the instruction |
| byte_op | input | 1 | 1 = byte operation, 0 = word |
| ext_word | input | 16 | Extension word (offset, address or immediate) |
| pc_in | input | 16 | Address of the extension word |
| reg_rdata | input | 16 | Register file read data for `reg_idx` |
| out_valid | output | 1 | Result strobe |
| out_is_reg | output | 1 | Operand is a register |
| out_reg_idx | output | 4 | Selected register |
| out_is_mem | output | 1 | Operand is in memory |
| out_addr | output | 16 | Effective address |
| out_is_imm | output | 1 | Operand is the immediate value |
| out_imm | output | 16 | Immediate value |
| out_illegal | output | 1 | Mode not allowed for this operand |
| wb_en | output | 1 | Pointer write-back request |
| wb_idx | output | 4 | Register to write back |
| wb_data | output | 16 | Advanced pointer value |

## Verification
The assertions assume that the caller supplies `reg_rdata` for the register named by `reg_idx` in the same cycle as `req_valid`, and that `pc_in` already points at the extension word. The bench honours this by computing every input of a request together in one driver task. All inputs are driven half a cycle away from the sampling edge. Pointer values near 0xFFFF and offsets that overflow are chosen on purpose, so that the wrap rules are exercised inside the assumed contract rather than outside it.

// File: rtl/opaddr_pkg.sv
// Shared types for the operand addressing unit.
// Assumes a 3-bit mode code whose numeric order is part of the interface.
package opaddr_pkg;

    typedef enum logic [2:0] {
        AM_REG = 3'd0,
        AM_IDX = 3'd1,
        AM_SYM = 3'd2,
        AM_ABS = 3'd3,
        AM_IND = 3'd4,
        AM_INC = 3'd5,
        AM_IMM = 3'd6,
        AM_RSV = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        OK_REG = 2'd0,
        OK_MEM = 2'd1,
        OK_IMM = 2'd2,
        OK_BAD = 2'd3
    } okind_e;

endpackage

// File: rtl/opaddr_mode_check.sv
// Classifies a request into register / memory / immediate / illegal and
// flags post-increment. Assumes destinations allow only codes 0..3.
module opaddr_mode_check
    import opaddr_pkg::*;
(
    input  logic   is_dst,
    input  amode_e mode,
    output okind_e kind,
    output logic   post_inc
);

    // Map the mode code and operand role onto an outcome class.
    always_comb begin
        kind     = OK_BAD;
        post_inc = 1'b0;
        if (is_dst && (mode > AM_ABS)) begin
            kind = OK_BAD;
        end else begin
            case (mode)
                AM_REG:                         kind = OK_REG;
                AM_IDX, AM_SYM, AM_ABS, AM_IND: kind = OK_MEM;
                AM_INC: begin
                    kind     = OK_MEM;
                    post_inc = 1'b1;
                end
                AM_IMM:                         kind = OK_IMM;
                default:                        kind = OK_BAD;
            endcase
        end
    end

endmodule

// File: rtl/opaddr_ea_calc.sv
// Computes the memory effective address for each memory mode.
// Assumes the sums wrap at the data width; non-memory modes return zero.
module opaddr_ea_calc
    import opaddr_pkg::*;
#(
    parameter int DW = 16
) (
    input  amode_e        mode,
    input  logic [DW-1:0] ext_word,
    input  logic [DW-1:0] pc_in,
    input  logic [DW-1:0] reg_rdata,
    output logic [DW-1:0] addr
);

    // Select the base and offset that form the address.
    always_comb begin
        case (mode)
            AM_IDX:         addr = ext_word + reg_rdata;
            AM_SYM:         addr = ext_word + pc_in;
            AM_ABS:         addr = ext_word;
            AM_IND, AM_INC: addr = reg_rdata;
            default:        addr = '0;
        endcase
    end

endmodule

// File: rtl/opaddr_ptr_step.sv
// Produces the advanced pointer for post-increment. The step depends on the
// operand size. Assumes both step sizes fit the data width.
module opaddr_ptr_step #(
    parameter int DW        = 16,
    parameter int WORD_STEP = 2,
    parameter int BYTE_STEP = 1
) (
    input  logic          byte_op,
    input  logic [DW-1:0] ptr,
    output logic [DW-1:0] ptr_next
);

    localparam logic [DW-1:0] WSTEP = DW'(WORD_STEP);
    localparam logic [DW-1:0] BSTEP = DW'(BYTE_STEP);

    generate
        if (WORD_STEP == BYTE_STEP) begin : g_same
            // One step size serves both operand widths.
            assign ptr_next = ptr + WSTEP;
        end else begin : g_split
            // Pick the step from the operand size.
            assign ptr_next = ptr + (byte_op ? BSTEP : WSTEP);
        end
    endgenerate

endmodule

// File: rtl/opaddr_unit.sv
// Operand addressing unit top. Classifies the operand and computes its
// location, then registers the result with a one-cycle latency. Assumes
// reg_rdata belongs to reg_idx and pc_in is the extension word's address.
module opaddr_unit
    import opaddr_pkg::*;
#(
    parameter int DW        = 16,
    parameter int RW        = 4,
    parameter int WORD_STEP = 2,
    parameter int BYTE_STEP = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          is_dst,
    input  logic [2:0]    mode,
    input  logic [RW-1:0] reg_idx,
    input  logic          byte_op,
    input  logic [DW-1:0] ext_word,
    input  logic [DW-1:0] pc_in,
    input  logic [DW-1:0] reg_rdata,
    output logic          out_valid,
    output logic          out_is_reg,
    output logic [RW-1:0] out_reg_idx,
    output logic          out_is_mem,
    output logic [DW-1:0] out_addr,
    output logic          out_is_imm,
    output logic [DW-1:0] out_imm,
    output logic          out_illegal,
    output logic          wb_en,
    output logic [RW-1:0] wb_idx,
    output logic [DW-1:0] wb_data
);

    localparam logic [DW-1:0] WSTEP = DW'(WORD_STEP);
    localparam logic [DW-1:0] BSTEP = DW'(BYTE_STEP);

    amode_e        mode_e;
    okind_e        kind;
    logic          post_inc;
    logic [DW-1:0] ea;
    logic [DW-1:0] ptr_next;

    assign mode_e = amode_e'(mode);

    opaddr_mode_check u_check (
        .is_dst   (is_dst),
        .mode     (mode_e),
        .kind     (kind),
        .post_inc (post_inc)
    );

    opaddr_ea_calc #(.DW(DW)) u_ea (
        .mode      (mode_e),
        .ext_word  (ext_word),
        .pc_in     (pc_in),
        .reg_rdata (reg_rdata),
        .addr      (ea)
    );

    opaddr_ptr_step #(.DW(DW), .WORD_STEP(WORD_STEP), .BYTE_STEP(BYTE_STEP)) u_step (
        .byte_op  (byte_op),
        .ptr      (reg_rdata),
        .ptr_next (ptr_next)
    );

    // Capture the classified result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_is_reg  <= 1'b0;
            out_reg_idx <= '0;
            out_is_mem  <= 1'b0;
            out_addr    <= '0;
            out_is_imm  <= 1'b0;
            out_imm     <= '0;
            out_illegal <= 1'b0;
            wb_en       <= 1'b0;
            wb_idx      <= '0;
            wb_data     <= '0;
        end else begin
            out_valid   <= req_valid;
            out_is_reg  <= req_valid && (kind == OK_REG);
            out_reg_idx <= (kind == OK_REG) ? reg_idx : '0;
            out_is_mem  <= req_valid && (kind == OK_MEM);
            out_addr    <= (kind == OK_MEM) ? ea : '0;
            out_is_imm  <= req_valid && (kind == OK_IMM);
            out_imm     <= (kind == OK_IMM) ? ext_word : '0;
            out_illegal <= req_valid && (kind == OK_BAD);
            wb_en       <= req_valid && post_inc;
            wb_idx      <= post_inc ? reg_idx : '0;
            wb_data     <= post_inc ? ptr_next : '0;
        end
    end

    // R3: an illegal result carries no other outcome or write-back.
    p_illegal_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (!out_is_reg && !out_is_mem && !out_is_imm && !wb_en));

    // R10: a valid result has exactly one outcome class.
    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones({out_is_reg, out_is_mem, out_is_imm, out_illegal}) == 1);

    // R10: no outcome flag without the strobe.
    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_is_reg && !out_is_mem && !out_is_imm && !out_illegal && !wb_en));

    // R8: write-back only goes with a memory address, and the pointer advances by a legal step.
    p_wb_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (out_is_mem && ((wb_data - out_addr == WSTEP) || (wb_data - out_addr == BSTEP))));

    // R9: an immediate never produces a write-back.
    p_imm_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_is_imm |-> !wb_en);

    // R1: reset clears the strobe on the following edge.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !wb_en));

endmodule

// File: tb/opaddr_unit_bench.sv
// Scoreboard bench: a driver task queues expected results, a monitor compares.
module opaddr_unit_bench;

    localparam int DW = 16;
    localparam int RW = 4;

    typedef struct {
        string       tag;
        logic [1:0]  kind;   // 0 reg, 1 mem, 2 imm, 3 illegal
        logic [RW-1:0] ridx;
        logic [DW-1:0] addr;
        logic [DW-1:0] imm;
        logic          wb;
        logic [DW-1:0] wbd;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          is_dst = 1'b0;
    logic [2:0]    mode = '0;
    logic [RW-1:0] reg_idx = '0;
    logic          byte_op = 1'b0;
    logic [DW-1:0] ext_word = '0;
    logic [DW-1:0] pc_in = '0;
    logic [DW-1:0] reg_rdata = '0;
    logic          out_valid, out_is_reg, out_is_mem, out_is_imm, out_illegal, wb_en;
    logic [RW-1:0] out_reg_idx, wb_idx;
    logic [DW-1:0] out_addr, out_imm, wb_data;

    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    opaddr_unit u_opaddr_unit (
        .clk, .rst_n, .req_valid, .is_dst, .mode, .reg_idx, .byte_op,
        .ext_word, .pc_in, .reg_rdata, .out_valid, .out_is_reg, .out_reg_idx,
        .out_is_mem, .out_addr, .out_is_imm, .out_imm, .out_illegal,
        .wb_en, .wb_idx, .wb_data
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // Driver: apply one request and queue what the requirements predict.
    task automatic send(input string tag, input logic d, input logic [2:0] m,
                        input logic [RW-1:0] ri, input logic b, input logic [DW-1:0] ext,
                        input logic [DW-1:0] pc, input logic [DW-1:0] rd);
        exp_t e;
        @(negedge clk);
        #1;
        req_valid = 1'b1; is_dst = d; mode = m; reg_idx = ri; byte_op = b;
        ext_word = ext; pc_in = pc; reg_rdata = rd;
        e.tag = tag; e.ridx = '0; e.addr = '0; e.imm = '0; e.wb = 1'b0; e.wbd = '0;
        if ((d && m > 3'd3) || m == 3'd7) e.kind = 2'd3;
        else if (m == 3'd0) begin e.kind = 2'd0; e.ridx = ri; end
        else if (m == 3'd6) begin e.kind = 2'd2; e.imm = ext; end
        else begin
            e.kind = 2'd1;
            case (m)
                3'd1: e.addr = ext + rd;
                3'd2: e.addr = ext + pc;
                3'd3: e.addr = ext;
                default: e.addr = rd;
            endcase
            if (m == 3'd5) begin e.wb = 1'b1; e.wbd = rd + (b ? 16'd1 : 16'd2); end
        end
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            req_valid = 1'b0;
        end
    endtask

    // Monitor: compare each result against the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check("R10 unexpected result", 32'd1, 32'd0);
            end else begin
                exp_t e;
                logic [1:0] k;
                e = sb.pop_front();
                k = out_illegal ? 2'd3 : out_is_imm ? 2'd2 : out_is_mem ? 2'd1 : 2'd0;
                check({e.tag, " kind"}, {30'd0, k}, {30'd0, e.kind});
                check({e.tag, " flags"}, {28'd0, out_is_reg, out_is_mem, out_is_imm, out_illegal},
                      {28'd0, e.kind == 2'd0, e.kind == 2'd1, e.kind == 2'd2, e.kind == 2'd3});
                if (e.kind == 2'd0) check({e.tag, " reg"}, 32'(out_reg_idx), 32'(e.ridx));
                if (e.kind == 2'd1) check({e.tag, " addr"}, 32'(out_addr), 32'(e.addr));
                if (e.kind == 2'd2) check({e.tag, " imm"}, 32'(out_imm), 32'(e.imm));
                check({e.tag, " wb_en"}, 32'(wb_en), 32'(e.wb));
                if (e.wb) begin
                    check({e.tag, " wb_data"}, 32'(wb_data), 32'(e.wbd));
                    check({e.tag, " wb_idx"}, 32'(wb_idx), 32'(e.ridx === '0 ? reg_idx_q : e.ridx));
                end
            end
        end
    end

    // Index of the last post-increment request, for the write-back target check.
    logic [RW-1:0] reg_idx_q = '0;
    always @(posedge clk) reg_idx_q <= reg_idx;

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check("R1 valid in reset", 32'(out_valid), 32'd0);
        check("R1 wb in reset", 32'(wb_en), 32'd0);
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check("R10 idle after reset", 32'(out_valid), 32'd0);

        send("R2 src reg", 0, 3'd0, 4'd9, 0, 16'h1111, 16'h0100, 16'hAAAA);
        send("R2 dst reg", 1, 3'd0, 4'd15, 1, 16'h0, 16'h0100, 16'h0);
        send("R4 indexed", 0, 3'd1, 4'd5, 0, 16'h0002, 16'h0200, 16'h3000);
        send("R4 indexed wrap", 1, 3'd1, 4'd6, 0, 16'hFFFE, 16'h0200, 16'h0004);
        send("R11 indexed byte", 0, 3'd1, 4'd5, 1, 16'h0002, 16'h0200, 16'h3000);
        send("R5 symbolic", 0, 3'd2, 4'd0, 0, 16'h0010, 16'h8000, 16'h0);
        send("R5 symbolic wrap dst", 1, 3'd2, 4'd0, 1, 16'hF000, 16'h2000, 16'h0);
        send("R6 absolute", 1, 3'd3, 4'd2, 0, 16'h0120, 16'h4000, 16'h5555);
        send("R7 indirect", 0, 3'd4, 4'd10, 0, 16'h9999, 16'h0, 16'h1234);
        send("R11 indirect byte", 0, 3'd4, 4'd10, 1, 16'h9999, 16'h0, 16'h1234);
        idle(2);
        @(negedge clk);
        #2;
        check("R10 no result without request", 32'(out_valid), 32'd0);
        send("R8 autoinc word", 0, 3'd5, 4'd11, 0, 16'h0, 16'h0, 16'h2000);
        send("R8 autoinc byte", 0, 3'd5, 4'd12, 1, 16'h0, 16'h0, 16'h2001);
        send("R8 autoinc wrap word", 0, 3'd5, 4'd4, 0, 16'h0, 16'h0, 16'hFFFF);
        send("R8 autoinc wrap byte", 0, 3'd5, 4'd7, 1, 16'h0, 16'h0, 16'hFFFF);
        send("R9 immediate", 0, 3'd6, 4'd0, 0, 16'h002D, 16'h0, 16'h7777);
        send("R9 immediate byte", 0, 3'd6, 4'd0, 1, 16'hBEEF, 16'h0, 16'h7777);
        for (int m = 4; m < 8; m++)
            send("R3 dst illegal", 1, 3'(m), 4'd8, 0, 16'h0044, 16'h0, 16'h0088);
        send("R3 src reserved", 0, 3'd7, 4'd8, 0, 16'h0044, 16'h0, 16'h0088);
        idle(3);
        check("R10 queue drained", 32'(sb.size()), 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule